// File: doc/BRIEF.md
# Timer Channel with PWM and Input Capture

One channel of a 16-bit timer. A free-running counter and its overflow pulse come from outside and are shared by all channels. The channel has two modes. In capture mode it stores the counter value when a chosen edge appears on an asynchronous input pin. In compare mode it compares the counter with a stored value and drives an output pin. Compare mode works either as a simple toggle-on-match output or as an unbuffered PWM whose period ends at each counter overflow.

The 16-bit channel register is reached over an 8-bit bus as two bytes. An interlock keeps each 16-bit transfer whole. In capture mode, reading the upper byte freezes captures until the lower byte is read. In compare mode, writing the upper byte stops compare matches until the lower byte is written.

In PWM operation, a force-maximum control holds the output at full duty. The control is sampled only at an overflow, so a change applies from the next period onward. A polarity input selects which pin level counts as active.

Top module: `tim_chan`

## Requirements
- R1: With `mode_i` = 00 the channel is in capture mode. On each selected edge of `pin_i` (`edge_sel_i`: 00 none, 01 rising, 10 falling, 11 both) the channel register loads `cnt_i`. The value stored is `cnt_i` as sampled at the third rising clock edge after the pin changes: two edges for synchronizing and one for loading.
- R2: `flag_o` goes high in the cycle after a capture. It stays high until `flag_clr_i` is seen without a capture in the same cycle.
- R3: In capture mode, a read of the upper byte (`addr_i` = 0) blocks captures. The block starts in that read's own cycle and lasts through the cycle that reads the lower byte (`addr_i` = 1). Edges during the block are lost and the flag does not set.
- R4: With `mode_i` ≠ 00 and `tov_en_i` = 0, each clock edge at which `cnt_i` equals the channel register toggles the output's active state.
- R5: In compare mode, a write of the upper byte blocks compare matches. The block starts in that write's own cycle and lasts through the cycle that writes the lower byte.
- R6: With `mode_i` ≠ 00 and `tov_en_i` = 1 (PWM), an edge with `ovf_i` high makes the output active. An edge with a compare match makes it inactive. When both occur on the same edge, overflow wins.
- R7: In PWM, `max_i` is sampled at each overflow edge. While the sampled value is 1, compare matches are ignored, so the output stays active for the whole period. A change to `max_i` in mid-period therefore applies only from the next period.
- R8: `pwm_o` equals `pol_i` while active and `~pol_i` while inactive. Reset leaves the output inactive and `flag_o` low.
- R9: `wr_i` writes `wdata_i` to the upper byte (`addr_i` = 0) or the lower byte (`addr_i` = 1). `rdata_o` shows the byte selected by `addr_i` without any clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Shared counter value |
| ovf_i | input | 1 | Counter overflow pulse, one cycle long |
| mode_i | input | 2 | 00 selects capture; any other value selects compare |
| edge_sel_i | input | 2 | Capture edge select |
| tov_en_i | input | 1 | Selects PWM operation in compare mode |
| max_i | input | 1 | Force full duty |
| pol_i | input | 1 | Active output level |
| pin_i | input | 1 | Asynchronous capture input |
| flag_clr_i | input | 1 | Clears the capture flag |
| wr_i | input | 1 | Byte write strobe |
| rd_i | input | 1 | Byte read strobe |
| addr_i | input | 1 | 0 selects the upper byte, 1 the lower byte |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data |
| flag_o | output | 1 | Capture flag |
| pwm_o | output | 1 | Compare/PWM output pin |

## Verification
The assertions rely on the following input conditions:
- `ovf_i` is a single-cycle pulse.
- Read and write strobes are never asserted together.
- No bus write lands in the same cycle as a capture edge.

The stimulus holds to these conditions by construction. Every counter value and overflow pulse is applied for exactly one cycle. Between steps the counter returns to 16'hFFFF, a value the channel register never holds, so no match can occur during a bus access. The channel register has no reset value, so it is always written before any compare or PWM check.

// File: rtl/tim_chan_pkg.sv
package tim_chan_pkg;
  localparam logic SEL_HI = 1'b0;
  localparam logic SEL_LO = 1'b1;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [1:0] MODE_CAPTURE = 2'b00;
endpackage

// File: rtl/tim_chan_sync.sv
module tim_chan_sync
  import tim_chan_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pin_i,
  input  logic [1:0] edge_sel_i,
  output logic       hit_o
);
  localparam int unsigned LAST = STAGES;

  // sh_q[STAGES-1] is the synced level, sh_q[LAST] the previous one
  logic [LAST:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[LAST-1:0], pin_i};
  end

  logic rise, fall;
  assign rise = sh_q[LAST-1] & ~sh_q[LAST];
  assign fall = ~sh_q[LAST-1] & sh_q[LAST];

  always_comb begin
    unique case (edge_sel_e'(edge_sel_i))
      EDGE_RISE: hit_o = rise;
      EDGE_FALL: hit_o = fall;
      EDGE_BOTH: hit_o = rise | fall;
      default:   hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/tim_chan_regs.sv
module tim_chan_regs
  import tim_chan_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned BUS_W = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_mode_i,
  input  logic             cap_hit_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             flag_clr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic [CNT_W-1:0] ch_o,
  output logic             cmp_blk_o,
  output logic             flag_o
);
  logic [CNT_W-1:0] ch_q;
  logic rd_lock_q, wr_lock_q, flag_q;

  logic rd_hi, rd_lo, wr_hi, wr_lo;
  assign rd_hi = rd_i & (addr_i == SEL_HI);
  assign rd_lo = rd_i & (addr_i == SEL_LO);
  assign wr_hi = wr_i & (addr_i == SEL_HI);
  assign wr_lo = wr_i & (addr_i == SEL_LO);

  logic cap_blk, cap_ok;
  assign cap_blk = rd_lock_q | rd_hi;
  assign cap_ok  = cap_mode_i & cap_hit_i & ~cap_blk & ~wr_i;

  // contents undefined after reset by intent
  always_ff @(posedge clk_i) begin
    if (wr_hi)       ch_q[CNT_W-1:BUS_W] <= wdata_i;
    else if (wr_lo)  ch_q[BUS_W-1:0]     <= wdata_i;
    else if (cap_ok) ch_q                <= cnt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_lock_q <= 1'b0;
      wr_lock_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      if (cap_mode_i && rd_hi)      rd_lock_q <= 1'b1;
      else if (rd_lo)               rd_lock_q <= 1'b0;
      if (!cap_mode_i && wr_hi)     wr_lock_q <= 1'b1;
      else if (wr_lo)               wr_lock_q <= 1'b0;
      if (cap_ok)                   flag_q    <= 1'b1;
      else if (flag_clr_i)          flag_q    <= 1'b0;
    end
  end

  assign rdata_o   = (addr_i == SEL_HI) ? ch_q[CNT_W-1:BUS_W] : ch_q[BUS_W-1:0];
  assign ch_o      = ch_q;
  assign cmp_blk_o = ~cap_mode_i & (wr_lock_q | wr_hi);
  assign flag_o    = flag_q;

  assert_cap_load_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ok |=> ch_q == $past(cnt_i));
  assert_flag_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_ok |=> flag_o);
  assert_cap_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_lock_q && !wr_i) |=> $stable(ch_q));
  assert_lock_rd_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_mode_i && rd_hi) |=> rd_lock_q);
  assert_lock_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_mode_i && wr_hi) |=> cmp_blk_o || cap_mode_i);
endmodule

// File: rtl/tim_chan_out.sv
module tim_chan_out #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmp_mode_i,
  input  logic             tov_en_i,
  input  logic             max_i,
  input  logic             pol_i,
  input  logic             ovf_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] ch_i,
  input  logic             cmp_blk_i,
  output logic             pwm_o
);
  logic act_q, max_q, match;
  assign match = cmp_mode_i & ~cmp_blk_i & (cnt_i == ch_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      max_q <= 1'b0;
    end else if (cmp_mode_i) begin
      if (tov_en_i) begin
        if (ovf_i) begin
          act_q <= 1'b1;
          max_q <= max_i;          // period boundary: take new force-max
        end else if (match && !max_q) begin
          act_q <= 1'b0;
        end
      end else if (match) begin
        act_q <= ~act_q;
      end
    end
  end

  assign pwm_o = act_q ? pol_i : ~pol_i;

  assert_toggle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && !tov_en_i && match) |=> act_q != $past(act_q));
  assert_cmp_blocked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && !tov_en_i && cmp_blk_i) |=> $stable(act_q));
  assert_ovf_wins_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && tov_en_i && ovf_i) |=> act_q);
  assert_max_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_mode_i && tov_en_i && max_q && act_q) |=> act_q);
endmodule

// File: rtl/tim_chan.sv
module tim_chan
  import tim_chan_pkg::*;
#(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned SYNC_N = 2,
  parameter int unsigned BUS_W  = CNT_W / 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ovf_i,
  input  logic [1:0]       mode_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             tov_en_i,
  input  logic             max_i,
  input  logic             pol_i,
  input  logic             pin_i,
  input  logic             flag_clr_i,
  input  logic             wr_i,
  input  logic             rd_i,
  input  logic             addr_i,
  input  logic [BUS_W-1:0] wdata_i,
  output logic [BUS_W-1:0] rdata_o,
  output logic             flag_o,
  output logic             pwm_o
);
  logic cap_mode, cap_hit, cmp_blk;
  logic [CNT_W-1:0] ch;

  assign cap_mode = (mode_i == MODE_CAPTURE);

  tim_chan_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i, .rst_ni, .pin_i, .edge_sel_i, .hit_o(cap_hit)
  );

  tim_chan_regs #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_regs (
    .clk_i, .rst_ni, .cap_mode_i(cap_mode), .cap_hit_i(cap_hit), .cnt_i,
    .flag_clr_i, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .ch_o(ch), .cmp_blk_o(cmp_blk), .flag_o
  );

  tim_chan_out #(.CNT_W(CNT_W)) u_out (
    .clk_i, .rst_ni, .cmp_mode_i(~cap_mode), .tov_en_i, .max_i, .pol_i,
    .ovf_i, .cnt_i, .ch_i(ch), .cmp_blk_i(cmp_blk), .pwm_o
  );
endmodule

// File: tb/tim_chan_tb.sv
module tim_chan_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] cnt_i = 16'hFFFF;
  logic        ovf_i = 1'b0;
  logic [1:0]  mode_i = 2'b00;
  logic [1:0]  edge_sel_i = 2'b00;
  logic        tov_en_i = 1'b0, max_i = 1'b0, pol_i = 1'b1, pin_i = 1'b0;
  logic        flag_clr_i = 1'b0, wr_i = 1'b0, rd_i = 1'b0, addr_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        flag_o, pwm_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  tim_chan u_dut (
    .clk_i, .rst_ni, .cnt_i, .ovf_i, .mode_i, .edge_sel_i, .tov_en_i, .max_i,
    .pol_i, .pin_i, .flag_clr_i, .wr_i, .rd_i, .addr_i, .wdata_i, .rdata_o,
    .flag_o, .pwm_o
  );

  // {cnt, ovf, max, expected pwm_o} with pol=1, compare value 5
  localparam logic [18:0] VEC [12] = '{
    {16'd0, 1'b1, 1'b0, 1'b1},
    {16'd3, 1'b0, 1'b0, 1'b1},
    {16'd5, 1'b0, 1'b0, 1'b0},
    {16'd9, 1'b1, 1'b0, 1'b1},
    {16'd2, 1'b0, 1'b1, 1'b1},
    {16'd5, 1'b0, 1'b1, 1'b0},
    {16'd9, 1'b1, 1'b1, 1'b1},
    {16'd5, 1'b0, 1'b0, 1'b1},
    {16'd9, 1'b1, 1'b0, 1'b1},
    {16'd5, 1'b0, 1'b0, 1'b0},
    {16'd5, 1'b1, 1'b0, 1'b1},
    {16'd7, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] c, input logic o);
    @(negedge clk_i);
    cnt_i = c;
    ovf_i = o;
    @(posedge clk_i);
    #1;
    cnt_i = 16'hFFFF;
    ovf_i = 1'b0;
  endtask

  task automatic bus_wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i);
    #1 wr_i = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [7:0] d);
    @(negedge clk_i);
    rd_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(posedge clk_i);
    #1 rd_i = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    chk("R8 reset inactive", 16'(pwm_o), 16'd0);
    chk("R2 reset flag", 16'(flag_o), 16'd0);

    // load compare value 5 while in capture mode (no write lock there)
    bus_wr(1'b0, 8'h00);
    bus_wr(1'b1, 8'h05);
    mode_i = 2'b01;
    tov_en_i = 1'b1;

    // R6 R7 PWM vector walk
    for (int i = 0; i < 12; i++) begin
      max_i = VEC[i][1];
      step(VEC[i][18:3], VEC[i][2]);
      chk($sformatf("R6/R7 vec %0d", i), 16'(pwm_o), 16'(VEC[i][0]));
    end
    max_i = 1'b0;

    pol_i = 1'b0;
    #1 chk("R8 polarity 0 active", 16'(pwm_o), 16'd0);
    pol_i = 1'b1;

    // R9 byte access, R5 lock released by low write
    tov_en_i = 1'b0;
    bus_wr(1'b0, 8'h12);
    bus_wr(1'b1, 8'h34);
    bus_rd(1'b0, d);
    chk("R9 read hi", 16'(d), 16'h12);
    bus_rd(1'b1, d);
    chk("R9 read lo", 16'(d), 16'h34);

    // R4 toggle on match
    step(16'h1234, 1'b0);
    chk("R4 toggle 1", 16'(pwm_o), 16'd0);
    step(16'h1234, 1'b0);
    chk("R4 toggle 2", 16'(pwm_o), 16'd1);

    // R5 write lock
    bus_wr(1'b0, 8'h12);
    step(16'h1234, 1'b0);
    chk("R5 match blocked", 16'(pwm_o), 16'd1);
    bus_wr(1'b1, 8'h34);
    step(16'h1234, 1'b0);
    chk("R5 match after unlock", 16'(pwm_o), 16'd0);

    // R1 capture on rising edge
    mode_i = 2'b00;
    edge_sel_i = 2'b01;
    pin_i = 1'b1;
    for (int i = 0; i < 4; i++) step(16'h0100 + 16'(i), 1'b0);
    chk("R2 flag set", 16'(flag_o), 16'd1);
    bus_rd(1'b0, d);
    chk("R1 capture hi", 16'(d), 16'h01);
    bus_rd(1'b1, d);
    chk("R1 capture lo", 16'(d), 16'h02);
    flag_clr_i = 1'b1;
    step(16'hFFFF, 1'b0);
    flag_clr_i = 1'b0;
    chk("R2 flag cleared", 16'(flag_o), 16'd0);

    // R1 falling edge ignored with rising select
    pin_i = 1'b0;
    for (int i = 0; i < 4; i++) step(16'h0400 + 16'(i), 1'b0);
    chk("R1 wrong edge no flag", 16'(flag_o), 16'd0);

    // R3 read lock
    edge_sel_i = 2'b11;
    bus_rd(1'b0, d);
    pin_i = 1'b1;
    for (int i = 0; i < 4; i++) step(16'h0200 + 16'(i), 1'b0);
    chk("R3 locked no flag", 16'(flag_o), 16'd0);
    bus_rd(1'b1, d);
    chk("R3 locked value kept", 16'(d), 16'h02);
    pin_i = 1'b0;
    for (int i = 0; i < 4; i++) step(16'h0300 + 16'(i), 1'b0);
    chk("R3 unlocked flag", 16'(flag_o), 16'd1);
    bus_rd(1'b0, d);
    chk("R3 unlocked hi", 16'(d), 16'h03);
    bus_rd(1'b1, d);
    chk("R1 both-edge lo", 16'(d), 16'h02);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule